// File: doc/BRIEF.md
# Machine-Cycle Bus Strobe Generator

This block derives the bus timing of an 8-bit controller core from its oscillator clock. Each machine cycle lasts twelve oscillator periods and is split into six states, S1 to S6, of two phases each. The block drives the address-latch-enable strobe and the active-low program-store-enable read strobe from this sequence. It also turns the raw reset pin into a qualified core reset.

Two per-cycle flags from the core shape the strobes. One marks an external data transfer, which drops one address-latch pulse and both program-read pulses in that cycle. The other marks a code-table read. A single-bit auxiliary register can silence the address-latch strobe outside those two kinds of cycle, but only while code runs from internal memory. When the external-code strap is low, that register has no effect. The flags are captured at the end of each machine cycle and apply to the whole of the next cycle. Instruction decode and the address/data multiplexing are handled by other blocks.

Top module: `bus_strobe_gen`

## Requirements
- R1: After `arst_n` goes low, `stateIdx` is 0, `phaseIdx` is 0, `ale` is 0, `psen_n` is 1 and `coreRst` is 0. On every clock `phaseIdx` toggles. `stateIdx` (0 to 5 for S1 to S6) advances after phase 1, and wraps from 5 to 0.
- R2: In a cycle that is not an external data cycle, `ale` is 1 in exactly the clocks where (`stateIdx`,`phaseIdx`) is (0,1) or (3,1). This gives two pulses per twelve clocks.
- R3: In an external data cycle, the pulse at (0,1) is left out and the pulse at (3,1) is kept.
- R4: When `extCode_n` is 0 and the cycle is not an external data cycle, `psen_n` is 0 in both phases of states 1 and 4, and is 1 at all other times. When `extCode_n` is 1, `psen_n` stays 1.
- R5: In an external data cycle, `psen_n` stays 1 for the whole machine cycle.
- R6: When `auxRegData` bit 0 is 1 and `extCode_n` is 1, `ale` pulses only in cycles flagged as an external data cycle or a code-table read. In all other cycles it stays 0.
- R7: When `extCode_n` is 0, the disable bit has no effect and R2 and R3 apply.
- R8: `xdataCycle` and `codeReadCycle` are sampled on the clock edge that ends state 5, phase 1. They govern the machine cycle that follows. A flag that is raised and lowered within a cycle, without being seen at that edge, has no effect.
- R9: `coreRst` rises on the edge that ends a machine cycle, provided `rstPin` was sampled high on all 24 edges of the two complete machine cycles ending there. It falls on the first edge that samples `rstPin` low, and the count then starts again.
- R10: When `auxWrEn` is 1, bit 0 of `auxWrData` is stored as the ALE-disable bit. `auxRegData` returns that bit in position 0 with bits 7:1 at 0. The bit is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| rstPin | input | 1 | Raw reset pin, active high |
| extCode_n | input | 1 | External-code strap, low means fetch from external memory |
| xdataCycle | input | 1 | Next machine cycle performs an external data transfer |
| codeReadCycle | input | 1 | Next machine cycle performs a code-table read |
| auxWrEn | input | 1 | Write strobe for the auxiliary register |
| auxWrData | input | 8 | Write data, bit 0 is the ALE-disable bit |
| auxRegData | output | 8 | Auxiliary register read-back |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program store enable, active low |
| coreRst | output | 1 | Qualified core reset |
| stateIdx | output | 3 | Current state, 0 to 5 |
| phaseIdx | output | 1 | Current phase, 0 or 1 |

## Verification
A wrong state or phase count shows up within one clock on `stateIdx` and `phaseIdx`. It also moves the `ale` and `psen_n` edges away from their fixed positions within the twelve-clock frame. A flag latched at the wrong time changes the pulse counts of the following machine cycle, so the error appears no more than twelve clocks later. An error in the reset qualifier shows on `coreRst` at the first machine-cycle boundary after the fault, or on the first clock that samples a low pin. A reference model follows the tick position and the run length of high reset samples, and checks every output on every clock.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int NUM_STATES = 6;
  localparam int STATE_W    = $clog2(NUM_STATES);

  typedef struct packed {
    logic [STATE_W-1:0] nxtState;
    logic               nxtPhase;
    logic               lastTick;
  } seqStrobe_t;
endpackage

// File: rtl/cycle_seq.sv
module cycle_seq
  import strobe_pkg::*;
(
  input  logic               clk,
  input  logic               arst_n,
  output logic [STATE_W-1:0] stateIdx,
  output logic               phaseIdx,
  output seqStrobe_t         strobes
);
  localparam logic [STATE_W-1:0] LAST_STATE = STATE_W'(NUM_STATES - 1);

  always_comb begin
    strobes.lastTick = (stateIdx == LAST_STATE) && phaseIdx;
    strobes.nxtPhase = ~phaseIdx;
    if (!phaseIdx)             strobes.nxtState = stateIdx;
    else if (strobes.lastTick) strobes.nxtState = '0;
    else                       strobes.nxtState = stateIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stateIdx <= '0;
      phaseIdx <= 1'b0;
    end else begin
      stateIdx <= strobes.nxtState;
      phaseIdx <= strobes.nxtPhase;
    end
  end
endmodule

// File: rtl/strobe_dp.sv
module strobe_dp
  import strobe_pkg::*;
#(
  parameter int QUAL_CYCLES = 2,
  parameter int ALE_ST_A    = 0,
  parameter int ALE_ST_B    = 3,
  parameter int PSEN_ST_A   = 1,
  parameter int PSEN_ST_B   = 4,
  parameter int AUX_W       = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  seqStrobe_t       strobes,
  input  logic             rstPin,
  input  logic             extCode_n,
  input  logic             xdataCycle,
  input  logic             codeReadCycle,
  input  logic             auxWrEn,
  input  logic [AUX_W-1:0] auxWrData,
  output logic [AUX_W-1:0] auxRegData,
  output logic             ale,
  output logic             psen_n,
  output logic             coreRst
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(QUAL_CYCLES);

  logic             curX, curC, aleOff, cleanCyc;
  logic [CNT_W-1:0] qualCnt;
  logic             aleEnable, aleNext, psenNext_n, atA, atB;

  always_comb begin
    atA = (strobes.nxtState == STATE_W'(ALE_ST_A)) && strobes.nxtPhase;
    atB = (strobes.nxtState == STATE_W'(ALE_ST_B)) && strobes.nxtPhase;
    aleEnable  = !aleOff || !extCode_n || curX || curC;
    aleNext    = aleEnable && ((atA && !curX) || atB);
    psenNext_n = !(!extCode_n && !curX &&
                   ((strobes.nxtState == STATE_W'(PSEN_ST_A)) ||
                    (strobes.nxtState == STATE_W'(PSEN_ST_B))));
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      curX     <= 1'b0;
      curC     <= 1'b0;
      aleOff   <= 1'b0;
      ale      <= 1'b0;
      psen_n   <= 1'b1;
      qualCnt  <= '0;
      cleanCyc <= 1'b1;
    end else begin
      ale    <= aleNext;
      psen_n <= psenNext_n;
      if (auxWrEn) aleOff <= auxWrData[0];
      if (strobes.lastTick) begin
        curX     <= xdataCycle;
        curC     <= codeReadCycle;
        cleanCyc <= 1'b1;
        if (cleanCyc && rstPin) begin
          if (qualCnt != CNT_FULL) qualCnt <= qualCnt + 1'b1;
        end else begin
          qualCnt <= '0;
        end
      end else if (!rstPin) begin
        cleanCyc <= 1'b0;
        qualCnt  <= '0;
      end
    end
  end

  assign coreRst    = (qualCnt == CNT_FULL);
  assign auxRegData = {{(AUX_W-1){1'b0}}, aleOff};
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import strobe_pkg::*;
#(
  parameter int QUAL_CYCLES = 2,
  parameter int AUX_W       = 8
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             rstPin,
  input  logic             extCode_n,
  input  logic             xdataCycle,
  input  logic             codeReadCycle,
  input  logic             auxWrEn,
  input  logic [AUX_W-1:0] auxWrData,
  output logic [AUX_W-1:0] auxRegData,
  output logic             ale,
  output logic             psen_n,
  output logic             coreRst,
  output logic [2:0]       stateIdx,
  output logic             phaseIdx
);
  seqStrobe_t strobes;

  cycle_seq u_seq (
    .clk      (clk),
    .arst_n   (arst_n),
    .stateIdx (stateIdx),
    .phaseIdx (phaseIdx),
    .strobes  (strobes)
  );

  strobe_dp #(.QUAL_CYCLES(QUAL_CYCLES), .AUX_W(AUX_W)) u_dp (
    .clk           (clk),
    .arst_n        (arst_n),
    .strobes       (strobes),
    .rstPin        (rstPin),
    .extCode_n     (extCode_n),
    .xdataCycle    (xdataCycle),
    .codeReadCycle (codeReadCycle),
    .auxWrEn       (auxWrEn),
    .auxWrData     (auxWrData),
    .auxRegData    (auxRegData),
    .ale           (ale),
    .psen_n        (psen_n),
    .coreRst       (coreRst)
  );
endmodule

// File: rtl/strobe_gen_chk.sv
module strobe_gen_chk (
  input logic       clk,
  input logic       arst_n,
  input logic       rstPin,
  input logic       extCode_n,
  input logic [7:0] auxRegData,
  input logic       ale,
  input logic       psen_n,
  input logic       coreRst,
  input logic [2:0] stateIdx,
  input logic       phaseIdx
);
  a_r1_phase_toggles: assert property (@(posedge clk) disable iff (!arst_n)
    1'b1 |=> phaseIdx != $past(phaseIdx));

  a_r1_state_steps: assert property (@(posedge clk) disable iff (!arst_n)
    (phaseIdx && stateIdx != 3'd5) |=> stateIdx == $past(stateIdx) + 3'd1);

  a_r1_state_wraps: assert property (@(posedge clk) disable iff (!arst_n)
    (phaseIdx && stateIdx == 3'd5) |=> stateIdx == 3'd0);

  a_r2_ale_slot: assert property (@(posedge clk) disable iff (!arst_n)
    ale |-> phaseIdx && (stateIdx == 3'd0 || stateIdx == 3'd3));

  a_r4_psen_slot: assert property (@(posedge clk) disable iff (!arst_n)
    !psen_n |-> (stateIdx == 3'd1 || stateIdx == 3'd4));

  a_r4_psen_internal: assert property (@(posedge clk) disable iff (!arst_n)
    $past(extCode_n) |-> psen_n);

  a_r9_rst_needs_pin: assert property (@(posedge clk) disable iff (!arst_n)
    coreRst |-> $past(rstPin));

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!arst_n)
    auxRegData[7:1] == 7'd0);
endmodule

bind bus_strobe_gen strobe_gen_chk u_chk (
  .clk        (clk),
  .arst_n     (arst_n),
  .rstPin     (rstPin),
  .extCode_n  (extCode_n),
  .auxRegData (auxRegData),
  .ale        (ale),
  .psen_n     (psen_n),
  .coreRst    (coreRst),
  .stateIdx   (stateIdx),
  .phaseIdx   (phaseIdx)
);

// File: tb/sim_bus_strobe_gen.sv
`timescale 1ns/1ps
module sim_bus_strobe_gen;
  localparam time CLKP = 20ns;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic rstPin = 1'b0, extCode_n = 1'b0, xdataCycle = 1'b0, codeReadCycle = 1'b0;
  logic auxWrEn = 1'b0;
  logic [7:0] auxWrData = 8'd0;
  logic [7:0] auxRegData;
  logic ale, psen_n, coreRst, phaseIdx;
  logic [2:0] stateIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLKP/2) clk = ~clk;

  bus_strobe_gen u0 (.*);

  // behavioural reference model
  int  mTick = 0;
  bit  mX = 0, mC = 0, mOff = 0, mAle = 0, mPsen_n = 1, mRst = 0;
  int  mRun = 0;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      mTick = 0; mX = 0; mC = 0; mOff = 0; mAle = 0; mPsen_n = 1; mRst = 0; mRun = 0;
    end else begin
      int nt;
      bit wrap;
      bit en;
      wrap = (mTick == 11);
      nt = (mTick + 1) % 12;
      if (wrap) begin mX = xdataCycle; mC = codeReadCycle; end
      en = !mOff || !extCode_n || mX || mC;
      mAle = en && ((nt == 1 && !mX) || nt == 7);
      mPsen_n = !(!extCode_n && !mX && (nt / 2 == 1 || nt / 2 == 4));
      if (rstPin) begin
        mRun++;
        if (wrap && mRun >= 24) mRst = 1;
      end else begin
        mRun = 0; mRst = 0;
      end
      if (auxWrEn) mOff = auxWrData[0];
      mTick = nt;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (arst_n && !done) begin
      chk("R1 stateIdx", stateIdx, mTick / 2);
      chk("R1 phaseIdx", phaseIdx, mTick % 2);
      chk("R2/R3/R6/R7/R8 ale", ale, mAle);
      chk("R4/R5/R8 psen_n", psen_n, mPsen_n);
      chk("R9 coreRst", coreRst, mRst);
      chk("R10 auxRegData", auxRegData, {7'd0, mOff});
    end
  end

  task automatic toBoundary();
    do @(negedge clk); while (mTick != 0);
  endtask

  task automatic runCycles(input int n, input string req, input int expAle, input int expPsen);
    int aleCnt = 0;
    int psenCnt = 0;
    logic pa, pp;
    toBoundary();
    pa = ale; pp = psen_n;
    for (int i = 0; i < n * 12; i++) begin
      @(negedge clk);
      if (ale && !pa) aleCnt++;
      if (!psen_n && pp) psenCnt++;
      pa = ale; pp = psen_n;
    end
    chk({req, " ale pulses"}, aleCnt, expAle);
    chk({req, " psen pulses"}, psenCnt, expPsen);
  endtask

  task automatic writeAux(input logic [7:0] d);
    auxWrData = d; auxWrEn = 1'b1;
    @(negedge clk);
    auxWrEn = 1'b0; auxWrData = 8'd0;
  endtask

  initial begin
    #(CLKP * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLKP * 3 + CLKP/4);
    // R1 and R10 reset values
    chk("R1 reset stateIdx", stateIdx, 0);
    chk("R1 reset phaseIdx", phaseIdx, 0);
    chk("R1 reset ale", ale, 0);
    chk("R1 reset psen_n", psen_n, 1);
    chk("R1 reset coreRst", coreRst, 0);
    chk("R10 reset auxRegData", auxRegData, 0);
    @(negedge clk); arst_n = 1'b1;

    // R2 R4 external code, plain fetch cycles
    extCode_n = 1'b0;
    runCycles(4, "R2 R4 normal", 8, 8);
    // R3 R5 external data cycles
    xdataCycle = 1'b1;
    runCycles(3, "R3 R5 xdata", 3, 0);
    xdataCycle = 1'b0;
    // R4 internal code, no program reads
    extCode_n = 1'b1;
    runCycles(4, "R4 internal", 8, 0);
    // R10 write and read back
    writeAux(8'hFF);
    chk("R10 readback set", auxRegData, 1);
    // R6 disabled ALE
    runCycles(3, "R6 disabled", 0, 0);
    codeReadCycle = 1'b1;
    runCycles(2, "R6 coderead", 4, 0);
    codeReadCycle = 1'b0;
    xdataCycle = 1'b1;
    runCycles(2, "R6 xdata", 2, 0);
    xdataCycle = 1'b0;
    // R7 strap overrides disable
    extCode_n = 1'b0;
    runCycles(3, "R7 override", 6, 6);
    writeAux(8'h00);
    chk("R10 readback clear", auxRegData, 0);
    // R8 flag pulse that misses the sampling edge
    toBoundary();
    repeat (3) @(negedge clk);
    xdataCycle = 1'b1;
    repeat (4) @(negedge clk);
    xdataCycle = 1'b0;
    runCycles(2, "R8 missed flag", 4, 4);
    // R9 reset qualification
    toBoundary();
    rstPin = 1'b1;
    repeat (23) @(negedge clk);
    chk("R9 before two cycles", coreRst, 0);
    @(negedge clk);
    chk("R9 after two cycles", coreRst, 1);
    repeat (5) @(negedge clk);
    rstPin = 1'b0;
    @(negedge clk);
    chk("R9 drops on low", coreRst, 0);
    rstPin = 1'b1;
    toBoundary();
    repeat (12) @(negedge clk);
    chk("R9 restart not yet", coreRst, 0);
    repeat (12) @(negedge clk);
    chk("R9 restart done", coreRst, 1);
    rstPin = 1'b0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule